// File: doc/BRIEF.md
# Serial Flash Address-Width Probe

This block is the SPI master front end of a boot loader. After a start pulse it works out how many address bytes the attached serial memory needs, then keeps the memory selected and streams boot bytes out through a valid/ready port. The bus runs in SPI mode 3 (clock idles high, output changes on the falling edge, input sampled on the rising edge), bytes travel MSB first, and the block drives chip select itself around each probe.

Each probe lowers chip select and sends the read opcode 0x03. It then sends a growing count of zero address bytes (one, two, three, then four) and clocks in one byte. MISO has a pull-up, and a memory leaves it undriven until it has seen its full address. So a byte other than 0xFF marks the current count as correct. That byte becomes the first stream byte, and its upper nibble is exported as a configuration code for the rest of the boot. Probing uses a slower clock divider setting than streaming. If no probe succeeds, a failure flag is raised and the block stays quiet until reset.

Top module: `spi_addr_probe`

## Requirements
- R1: After reset, spi_cs_n and spi_sck are high, and m_valid, detect_done and detect_fail are low.
- R2: Probe n (n = 1, 2, 3, 4, in that order) lowers spi_cs_n, sends 0x03 MSB first on spi_mosi, then n bytes of 0x00, then one more byte, which is 24+8(n-1) rising SCK edges in total before spi_cs_n rises again.
- R3: SCK is high whenever no byte is moving, spi_mosi changes only while SCK is low, and spi_miso is sampled as SCK rises.
- R4: Each low phase and each high phase of SCK inside a byte lasts probe_half+1 clock cycles during probing and boot_half+1 clock cycles during streaming.
- R5: When a probe reads a byte other than 0xFF, detect_done is high for exactly one cycle and width_code is n-1 (0 = 8, 1 = 16, 2 = 24, 3 = 32 address bits).
- R6: When a probe reads 0xFF, spi_cs_n stays high for at least 2*(probe_half+1) cycles before the next probe lowers it.
- R7: If all four probes read 0xFF, detect_fail rises and stays high with spi_cs_n and spi_sck high until reset, and detect_done never pulses.
- R8: After detection, spi_cs_n stays low. The probe byte is offered first on m_data, then the following memory bytes in address order with none skipped.
- R9: From the detect_done cycle on, cfg_nibble equals the upper four bits (bits 7:4) of the first stream byte.
- R10: While m_valid is high and m_ready is low, m_data and m_valid hold and spi_sck stays high. No new byte is clocked until the waiting one is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle pulse that begins probing from idle |
| probe_half | input | 8 | SCK half period minus one, in clock cycles, used while probing |
| boot_half | input | 8 | SCK half period minus one, in clock cycles, used while streaming |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Memory select, active low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory, pulled up |
| width_code | output | 2 | Detected address width code |
| detect_done | output | 1 | One-cycle pulse when the width is found |
| detect_fail | output | 1 | Sticky flag: no width matched |
| cfg_nibble | output | 4 | Upper nibble of the first boot byte |
| m_data | output | 8 | Stream byte |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Consumer accepts the stream byte |

## Verification
A probe byte is final on the clock edge that raises SCK for the eighth time. detect_done, width_code, cfg_nibble and the first m_data all show the result in the cycle after that edge, so the bench waits for detect_done by sampling each falling clock edge and reads every result in that same sample. Stream bytes are checked only in samples where m_valid and m_ready are both high, because the handshake completes on the next rising edge. The bench drives inputs one nanosecond after a rising edge. Pulse widths, chip-select gaps and MOSI stability are measured every cycle at the falling clock edge against the half-period setting of the current phase, and SCK edge counts per select window come from a memory model that counts edges directly.

// File: rtl/spi_probe_pkg.sv
package spi_probe_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_OPCODE,
    PS_ADDR,
    PS_READ,
    PS_GAP,
    PS_STREAM,
    PS_FAIL
  } probe_state_e;

  localparam logic [7:0] READ_OPCODE    = 8'h03;
  localparam int unsigned MAX_ADDR_BYTES = 4;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == limit);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [CNT_W-1:0]  half_lim,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int IDX_W = $clog2(EDGES);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              sck_q, sck_d;
  logic              mosi_q, mosi_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              tick;

  spi_half_timer #(.CNT_W(CNT_W)) u_half (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_q),
    .limit (half_lim),
    .tick  (tick)
  );

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sck_d  = sck_q;
    mosi_d = mosi_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = '0;
      tx_d   = tx_byte;
    end else if (tick) begin
      if (!idx_q[0]) begin
        sck_d  = 1'b0;
        mosi_d = tx_q[BYTE_W-1];
        tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
      end else begin
        sck_d = 1'b1;
        rx_d  = {rx_q[BYTE_W-2:0], miso};
      end
      if (idx_q == IDX_W'(EDGES - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sck_q  <= 1'b1;
      mosi_q <= 1'b1;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R3: output bit moves only on a falling SCK edge
  a_r3_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_q) |-> $fell(sck_q));
  // R3: clock parked high between bytes
  a_r3_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck_q);
  // R3: a finished byte always ends on a rising edge
  a_r3_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $rose(sck_q));
endmodule

// File: rtl/spi_addr_probe.sv
module spi_addr_probe
  import spi_probe_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  probe_half,
  input  logic [DIV_W-1:0]  boot_half,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [1:0]        width_code,
  output logic              detect_done,
  output logic              detect_fail,
  output logic [3:0]        cfg_nibble,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready
);
  localparam int WSEL_W = $clog2(MAX_ADDR_BYTES);
  localparam int NIB_W  = BYTE_W / 2;
  localparam logic [WSEL_W-1:0] LAST_WSEL = WSEL_W'(MAX_ADDR_BYTES - 1);

  probe_state_e      state_q, state_d;
  logic              cs_n_q, cs_n_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic [WSEL_W-1:0] left_q, left_d;
  logic [WSEL_W-1:0] width_q, width_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;
  logic [NIB_W-1:0]  nib_q, nib_d;
  logic [BYTE_W-1:0] mdata_q, mdata_d;
  logic              mvalid_q, mvalid_d;
  logic              gap_half_q, gap_half_d;

  logic              x_go, x_busy, x_done;
  logic [BYTE_W-1:0] x_tx, x_rx;
  logic [DIV_W-1:0]  x_lim;
  logic              gap_tick;

  assign x_lim = (state_q == PS_STREAM) ? boot_half : probe_half;

  spi_byte_engine #(.CNT_W(DIV_W), .BYTE_W(BYTE_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (x_go),
    .tx_byte  (x_tx),
    .half_lim (x_lim),
    .miso     (spi_miso),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .busy     (x_busy),
    .done     (x_done),
    .rx_byte  (x_rx)
  );

  spi_half_timer #(.CNT_W(DIV_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == PS_GAP),
    .limit (probe_half),
    .tick  (gap_tick)
  );

  always_comb begin
    state_d    = state_q;
    cs_n_d     = cs_n_q;
    wsel_d     = wsel_q;
    left_d     = left_q;
    width_d    = width_q;
    done_d     = 1'b0;
    fail_d     = fail_q;
    nib_d      = nib_q;
    mdata_d    = mdata_q;
    mvalid_d   = mvalid_q;
    gap_half_d = gap_half_q;
    x_go       = 1'b0;
    x_tx       = '0;
    unique case (state_q)
      PS_IDLE: begin
        if (start) begin
          x_go    = 1'b1;
          x_tx    = BYTE_W'(READ_OPCODE);
          cs_n_d  = 1'b0;
          wsel_d  = '0;
          state_d = PS_OPCODE;
        end
      end
      PS_OPCODE: begin
        if (x_done) begin
          x_go    = 1'b1;
          left_d  = wsel_q;
          state_d = PS_ADDR;
        end
      end
      PS_ADDR: begin
        if (x_done) begin
          x_go = 1'b1;
          if (left_q != '0) left_d = left_q - 1'b1;
          else              state_d = PS_READ;
        end
      end
      PS_READ: begin
        if (x_done) begin
          if (x_rx != '1) begin
            width_d  = wsel_q;
            done_d   = 1'b1;
            nib_d    = x_rx[BYTE_W-1 -: NIB_W];
            mdata_d  = x_rx;
            mvalid_d = 1'b1;
            state_d  = PS_STREAM;
          end else begin
            cs_n_d     = 1'b1;
            gap_half_d = 1'b0;
            state_d    = PS_GAP;
          end
        end
      end
      PS_GAP: begin
        if (gap_tick) begin
          if (!gap_half_q) begin
            gap_half_d = 1'b1;
          end else if (wsel_q == LAST_WSEL) begin
            fail_d  = 1'b1;
            state_d = PS_FAIL;
          end else begin
            x_go    = 1'b1;
            x_tx    = BYTE_W'(READ_OPCODE);
            cs_n_d  = 1'b0;
            wsel_d  = wsel_q + 1'b1;
            state_d = PS_OPCODE;
          end
        end
      end
      PS_STREAM: begin
        if (x_done) begin
          mdata_d  = x_rx;
          mvalid_d = 1'b1;
        end else if (mvalid_q && m_ready) begin
          mvalid_d = 1'b0;
          x_go     = !x_busy;
        end else if (!mvalid_q) begin
          x_go = !x_busy;
        end
      end
      PS_FAIL: begin
        cs_n_d = 1'b1;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_IDLE;
      cs_n_q     <= 1'b1;
      wsel_q     <= '0;
      left_q     <= '0;
      width_q    <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      nib_q      <= '0;
      mdata_q    <= '0;
      mvalid_q   <= 1'b0;
      gap_half_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cs_n_q     <= cs_n_d;
      wsel_q     <= wsel_d;
      left_q     <= left_d;
      width_q    <= width_d;
      done_q     <= done_d;
      fail_q     <= fail_d;
      nib_q      <= nib_d;
      mdata_q    <= mdata_d;
      mvalid_q   <= mvalid_d;
      gap_half_q <= gap_half_d;
    end
  end

  assign spi_cs_n    = cs_n_q;
  assign width_code  = width_q;
  assign detect_done = done_q;
  assign detect_fail = fail_q;
  assign cfg_nibble  = nib_q;
  assign m_data      = mdata_q;
  assign m_valid     = mvalid_q;

  // R5: detection flag is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    detect_done |=> !detect_done);
  // R7: failure is sticky with the bus parked
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    detect_fail |=> detect_fail && spi_cs_n && spi_sck && !detect_done);
  // R10: waiting byte holds its value
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
  // R10: clock parked while a byte waits
  a_r10_sck_parked: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> spi_sck);
  // R8: select stays low once streaming
  a_r8_cs_low_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STREAM) |-> !spi_cs_n);
  // R6: select high during the inter-probe gap
  a_r6_cs_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_GAP) |-> spi_cs_n && spi_sck);
endmodule

// File: tb/spi_addr_probe_test.sv
`timescale 1ns/1ps
module spi_addr_probe_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] probe_half = 8'd1;
  logic [7:0] boot_half = 8'd0;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       miso_q = 1'b1;
  logic [1:0] width_code;
  logic       detect_done, detect_fail;
  logic [3:0] cfg_nibble;
  logic [7:0] m_data;
  logic       m_valid;
  logic       m_ready = 1'b0;

  always #2.5 clk = ~clk;

  spi_addr_probe uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .probe_half(probe_half), .boot_half(boot_half),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso_q),
    .width_code(width_code), .detect_done(detect_done), .detect_fail(detect_fail),
    .cfg_nibble(cfg_nibble), .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model state
  bit         armed = 0;
  int         dev_w = 0;
  logic [7:0] first_q = 8'h00;
  int         rbits = 0;
  logic [7:0] shin = 8'h00;
  int         sess = 0;
  int         sess_len [8];
  bit         opc_bad = 0, addr_bad = 0;

  function automatic logic [7:0] mem_byte(input int k);
    if (k == 0) return first_q;
    return 8'(((k * 29) + 7) ^ 8'hA5);
  endfunction

  always @(posedge spi_sck) begin
    if (armed && !spi_cs_n) begin
      shin = {shin[6:0], spi_mosi};
      rbits++;
      if (rbits % 8 == 0) begin
        if (rbits == 8) begin
          if (shin != 8'h03) opc_bad = 1;
        end else if (rbits / 8 - 1 <= sess + 1) begin
          if (shin != 8'h00) addr_bad = 1;
        end
      end
    end
  end

  always @(posedge spi_cs_n) begin
    if (armed) begin
      if (sess < 8) sess_len[sess] = rbits;
      sess++;
      rbits = 0;
      miso_q = 1'b1;
    end
  end

  always @(negedge spi_sck) begin
    if (armed && !spi_cs_n && dev_w != 0 && rbits >= 8 + 8 * dev_w) begin
      int idx;
      logic [7:0] b;
      idx = rbits - 8 - 8 * dev_w;
      b = mem_byte(idx / 8);
      miso_q = b[7 - (idx % 8)];
    end
  end

  // per-cycle monitor
  int   ph_cur = 1, bh_cur = 0;
  bit   streaming = 0;
  int   lo_run = 0, hi_run = 0;
  logic prev_sck = 1'b1, prev_mosi = 1'b1, prev_cs = 1'b1;
  bit   seen_low = 0, prev_stall = 0;
  logic [7:0] prev_data = 8'h00;
  int   per_bad = 0, mosi_bad = 0, gap_bad = 0, park_bad = 0, hold_bad = 0;

  always @(negedge clk) begin
    if (armed) begin
      if (!spi_sck) lo_run++;
      else begin
        if (!prev_sck && lo_run != (streaming ? bh_cur + 1 : ph_cur + 1)) per_bad++;
        lo_run = 0;
      end
      if (spi_mosi !== prev_mosi && spi_sck && prev_sck) mosi_bad++;
      if (spi_cs_n) hi_run++;
      else begin
        if (prev_cs && seen_low && hi_run < 2 * (ph_cur + 1)) gap_bad++;
        seen_low = 1;
        hi_run = 0;
      end
      if (m_valid && !spi_sck) park_bad++;
      if (prev_stall && (!m_valid || m_data !== prev_data)) hold_bad++;
      prev_stall = m_valid && !m_ready;
      prev_data  = m_data;
      prev_sck   = spi_sck;
      prev_mosi  = spi_mosi;
      prev_cs    = spi_cs_n;
      if (detect_done) streaming = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_case(input int w, input logic [7:0] first, input int ph, input int bh,
                          input int nbytes);
    int t;
    int k;
    int done_cnt;
    armed = 0;
    rst_n = 1'b0;
    start = 1'b0;
    m_ready = 1'b0;
    probe_half = 8'(ph);
    boot_half  = 8'(bh);
    dev_w = w; first_q = first; ph_cur = ph; bh_cur = bh;
    rbits = 0; sess = 0; opc_bad = 0; addr_bad = 0; miso_q = 1'b1;
    streaming = 0; lo_run = 0; hi_run = 0; seen_low = 0; prev_stall = 0;
    prev_sck = 1'b1; prev_mosi = 1'b1; prev_cs = 1'b1;
    per_bad = 0; mosi_bad = 0; gap_bad = 0; park_bad = 0; hold_bad = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n && spi_sck, "R1 bus idle", {spi_cs_n, spi_sck}, 3);
    chk(!m_valid && !detect_done && !detect_fail, "R1 flags low",
        {m_valid, detect_done, detect_fail}, 0);
    armed = 1;
    prev_mosi = spi_mosi;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    t = 0;
    do begin @(negedge clk); t++; end
    while (!detect_done && !detect_fail && t < 20000);

    for (int s = 0; s < sess && s < 8; s++)
      chk(sess_len[s] == 24 + 8 * s, "R2 probe edge count", sess_len[s], 24 + 8 * s);

    if (w == 0) begin
      chk(detect_fail, "R7 fail raised", detect_fail, 1);
      chk(sess == 4, "R2 four probes", sess, 4);
      done_cnt = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (!detect_fail || !spi_cs_n || !spi_sck || detect_done) done_cnt++;
      end
      chk(done_cnt == 0, "R7 stays parked", done_cnt, 0);
    end else begin
      chk(detect_done, "R5 detect pulse", detect_done, 1);
      chk(width_code == 2'(w - 1), "R5 width code", width_code, w - 1);
      chk(cfg_nibble == first[7:4], "R9 config nibble", cfg_nibble, first[7:4]);
      chk(sess == w - 1, "R2 failed probes before match", sess, w - 1);
      chk(m_valid && m_data == first, "R8 first byte is probe byte", m_data, first);
      k = 0;
      done_cnt = 0;
      t = 0;
      while (k < nbytes && t < 40000) begin
        @(posedge clk); #1 m_ready = ($urandom_range(0, 2) != 0);
        @(negedge clk); t++;
        if (detect_done) done_cnt++;
        if (spi_cs_n) done_cnt += 100;
        if (m_valid && m_ready) begin
          chk(m_data == mem_byte(k), "R8 stream byte", m_data, mem_byte(k));
          k++;
        end
      end
      chk(k == nbytes, "R8 stream count", k, nbytes);
      chk(done_cnt == 0, "R5 R8 single pulse and select low", done_cnt, 0);
      chk(cfg_nibble == first[7:4], "R9 nibble held", cfg_nibble, first[7:4]);
      // directed stall: R10
      m_ready = 1'b0;
      repeat (40) @(negedge clk);
      chk(m_valid && spi_sck, "R10 stall parks clock", {m_valid, spi_sck}, 3);
      m_ready = 1'b0;
    end
    chk(!opc_bad, "R2 opcode 0x03", opc_bad, 0);
    chk(!addr_bad, "R2 zero address bytes", addr_bad, 0);
    chk(mosi_bad == 0, "R3 mosi moves with clock low", mosi_bad, 0);
    chk(per_bad == 0, "R4 half period", per_bad, 0);
    chk(gap_bad == 0, "R6 select gap", gap_bad, 0);
    chk(park_bad == 0, "R10 clock high while waiting", park_bad, 0);
    chk(hold_bad == 0, "R10 hold under stall", hold_bad, 0);
    armed = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    run_case(1, 8'hFE, 1, 0, 10);
    run_case(4, 8'h7F, 2, 1, 10);
    run_case(0, 8'h00, 1, 0, 0);
    run_case(2, 8'h00, 0, 0, 12);
    run_case(3, 8'hC3, 3, 2, 8);
    for (int i = 0; i < 4; i++) begin
      int w, ph, bh;
      logic [7:0] f;
      w  = $urandom_range(1, 4);
      f  = 8'($urandom_range(0, 254));
      ph = $urandom_range(0, 3);
      bh = $urandom_range(0, 2);
      run_case(w, f, ph, bh, 16);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule